// File: doc/BRIEF.md
# Phased Byte Multiply Execution Unit

This unit executes the two multiply instructions of a small 8-bit accumulator core. One form multiplies the working register by an 8-bit immediate held in the instruction word. The other form multiplies it by a byte read from a banked 4 K-byte register file. Both multiplies are unsigned. The 16-bit result lands in a product register pair, which holds a high byte and a low byte.

Each instruction occupies one instruction cycle of four phase clocks. The unit counts the phases itself, starting from the first phase after reset. In phase 1 it decodes the instruction word and forms the file address. In phase 2 it strobes the file read and captures both operands. Phase 3 computes the product, and phase 4 writes the product pair. The caller must keep the instruction word, bank select, mode enable and index pointer steady across the whole instruction cycle. File-form operands come from one of three places: a bank picked by the bank select register, a fixed split access window, or an index pointer plus an offset when the extended addressing mode is on. The working register, the file contents and any condition flags are never written.

Top module: `byte_mul_unit`

## Requirements
- R1: A word whose upper byte is 0x0D is the immediate form. At the end of that instruction cycle, the product pair holds wreg times the lower byte.
- R2: A word whose bits [15:9] are 0000001 is the file form. Bit 8 is the bank-access bit and bits [7:0] are the offset. At the end of that instruction cycle, the product pair holds wreg times the byte on rf_rdata.
- R3: The multiply is unsigned 8x8 to 16 bits, with bits [15:8] on prod_hi and [7:0] on prod_lo. For example, E2h x C4h gives ADh/08h, C4h x B5h gives 8Ah/94h, and FFh x FFh gives FEh/01h. A zero result raises no flag.
- R4: File form with bit 8 = 1 reads address {bank_sel, offset}, whatever ext_en is.
- R5: File form with bit 8 = 0 and no indexing reads 0x000+offset when the offset is at most 5Fh, and 0xF00+offset otherwise. An offset above 5Fh is never indexed.
- R6: File form with bit 8 = 0, ext_en = 1 and offset at most 5Fh reads idx_ptr + offset, taken modulo 4096.
- R7: rf_rd_en is high only in phase 2 of a file-form instruction, and rf_raddr carries the operand address while it is high.
- R8: The product pair changes only at the clock edge that ends phase 4. It keeps its old value through phases 1 to 3.
- R9: Any other instruction word leaves the product pair unchanged and raises no read strobe. Examples are 0x0E55, 0x0C12 and 0x0400.
- R10: While rst_n is low at a clock edge, the product pair clears to zero and the phase count returns to phase 1. An instruction started after release completes four edges later.
- R11: Operands are captured at the edge that ends phase 2. Changes on rf_rdata after that edge do not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock, four per instruction cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 16 | Instruction word, held for the instruction cycle |
| wreg | input | 8 | Working register value |
| bank_sel | input | 4 | Bank select, upper file address bits |
| ext_en | input | 1 | Enables indexed offset addressing |
| idx_ptr | input | 12 | Index pointer for indexed addressing |
| rf_rdata | input | 8 | Register file read data |
| rf_raddr | output | 12 | Register file read address |
| rf_rd_en | output | 1 | Register file read strobe |
| prod_hi | output | 8 | Product high byte |
| prod_lo | output | 8 | Product low byte |

## Verification
The hardest case to reach is proving that the result really comes from the operands captured in phase 2. The same result could also come from data that changes later in the cycle. To test this, the bench drives rf_rdata from an address-keyed model and inverts that model's output from phase 3 onward. A late capture then yields a visibly different product. A second hard case is a reset that lands in the middle of an instruction. The bench releases reset two phases into an instruction and then expects the next product exactly four edges after release.

// File: rtl/bmu_pkg.sv
// Shared types for the phased multiply unit.
// Phase encoding and decoded-operation kinds; opcode constants for the two forms.
package bmu_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_LIT  = 2'd1,
        OP_REG  = 2'd2
    } op_kind_t;

    localparam logic [7:0] LIT_OPCODE = 8'h0D;
    localparam logic [6:0] REG_OPCODE = 7'b0000001;
endpackage

// File: rtl/bmu_phase_ctr.sv
// Four-phase sequencer.
// Steps Q1 -> Q2 -> Q3 -> Q4 -> Q1 on every clock; reset parks it in Q1.
// Assumes one clock per phase with no stalls.
module bmu_phase_ctr
    import bmu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase
);
    timeunit 1ns;
    timeprecision 1ps;

    // Advance the phase by one each clock, wrapping after Q4.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_Q1;
        else        phase <= phase_t'(phase + 2'd1);
    end

    // R10
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_Q4) |=> (phase == phase_t'($past(phase) + 2'd1)));

    // R10
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_Q4) |=> (phase == PH_Q1));
endmodule

// File: rtl/bmu_opnd_addr.sv
// Decode and operand address generation (phase 1).
// Classifies the instruction word and forms the 12-bit file address from
// the bank register, the split access window or the index pointer.
// Results are registered at the end of Q1 and held for the rest of the cycle.
// Assumes instr, bank_sel, ext_en and idx_ptr are stable during Q1.
module bmu_opnd_addr
    import bmu_pkg::*;
#(
    parameter int unsigned    DW           = 8,
    parameter int unsigned    AW           = 12,
    parameter logic [DW-1:0]  ACCESS_SPLIT = 8'h5F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_t           phase,
    input  logic [2*DW-1:0]  instr,
    input  logic [AW-DW-1:0] bank_sel,
    input  logic             ext_en,
    input  logic [AW-1:0]    idx_ptr,
    output op_kind_t         kind_q,
    output logic [DW-1:0]    lit_q,
    output logic [AW-1:0]    addr_q
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned BW = AW - DW;

    logic [DW-1:0] opc;
    logic [DW-1:0] ofs;
    logic          use_bank;
    logic          in_low_win;
    op_kind_t      kind_c;
    logic [AW-1:0] addr_c;

    assign opc        = instr[2*DW-1:DW];
    assign ofs        = instr[DW-1:0];
    assign use_bank   = instr[DW];
    assign in_low_win = (ofs <= ACCESS_SPLIT);

    // Classify the instruction word into immediate form, file form or neither.
    always_comb begin
        if (opc == LIT_OPCODE)            kind_c = OP_LIT;
        else if (opc[DW-1:1] == REG_OPCODE) kind_c = OP_REG;
        else                              kind_c = OP_NONE;
    end

    // Select banked, indexed or split-window addressing for the file operand.
    always_comb begin
        if (use_bank)
            addr_c = {bank_sel, ofs};
        else if (in_low_win && ext_en)
            addr_c = idx_ptr + {{BW{1'b0}}, ofs};
        else if (in_low_win)
            addr_c = {{BW{1'b0}}, ofs};
        else
            addr_c = {{BW{1'b1}}, ofs};
    end

    // Capture the decode results at the end of Q1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= OP_NONE;
            lit_q  <= '0;
            addr_q <= '0;
        end else if (phase == PH_Q1) begin
            kind_q <= kind_c;
            lit_q  <= ofs;
            addr_q <= addr_c;
        end
    end

    // R4
    bank_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_Q1 && kind_c == OP_REG && use_bank)
        |=> (addr_q[AW-1:DW] == $past(bank_sel)));

    // R5
    high_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_Q1 && kind_c == OP_REG && !use_bank && !in_low_win)
        |=> (addr_q[AW-1:DW] == {BW{1'b1}}));
endmodule

// File: rtl/bmu_prod_unit.sv
// Operand capture, multiply and product register (phases 2 to 4).
// Q2 latches W and the selected operand, Q3 forms the 16-bit product,
// Q4 commits it to the product pair unless the word was not a multiply.
// Assumes kind is held from the end of Q1 through Q4.
module bmu_prod_unit
    import bmu_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  phase_t          phase,
    input  op_kind_t        kind,
    input  logic [DW-1:0]   wreg,
    input  logic [DW-1:0]   lit,
    input  logic [DW-1:0]   rf_rdata,
    output logic [2*DW-1:0] prod
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned PW = 2 * DW;

    logic [DW-1:0] op_a;
    logic [DW-1:0] op_b;
    logic [PW-1:0] prod_nx;

    // Latch both operands at the end of Q2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_a <= '0;
            op_b <= '0;
        end else if (phase == PH_Q2) begin
            op_a <= wreg;
            op_b <= (kind == OP_LIT) ? lit : rf_rdata;
        end
    end

    // Form the unsigned product at the end of Q3.
    always_ff @(posedge clk) begin
        if (!rst_n)                prod_nx <= '0;
        else if (phase == PH_Q3)   prod_nx <= PW'(op_a) * PW'(op_b);
    end

    // Commit the product pair at the end of Q4 for recognised words only.
    always_ff @(posedge clk) begin
        if (!rst_n)                                prod <= '0;
        else if (phase == PH_Q4 && kind != OP_NONE) prod <= prod_nx;
    end

    // R8
    prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_Q4) |=> $stable(prod));

    // R9
    none_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_Q4 && kind == OP_NONE) |=> $stable(prod));

    // R10
    prod_clear_chk: assert property (@(posedge clk)
        (!rst_n) |=> (prod == '0));
endmodule

// File: rtl/byte_mul_unit.sv
// Top of the phased byte multiply unit.
// Wires the phase sequencer, decode/address stage and product stage, and
// raises the file read strobe in Q2 of a file-form instruction.
// Assumes a combinational register-file read: rf_rdata is valid in the
// same phase as rf_raddr/rf_rd_en.
module byte_mul_unit
    import bmu_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2*DW-1:0]  instr,
    input  logic [DW-1:0]    wreg,
    input  logic [AW-DW-1:0] bank_sel,
    input  logic             ext_en,
    input  logic [AW-1:0]    idx_ptr,
    input  logic [DW-1:0]    rf_rdata,
    output logic [AW-1:0]    rf_raddr,
    output logic             rf_rd_en,
    output logic [DW-1:0]    prod_hi,
    output logic [DW-1:0]    prod_lo
);
    timeunit 1ns;
    timeprecision 1ps;

    phase_t          phase;
    op_kind_t        kind_q;
    logic [DW-1:0]   lit_q;
    logic [AW-1:0]   addr_q;
    logic [2*DW-1:0] prod;

    bmu_phase_ctr u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    bmu_opnd_addr #(.DW(DW), .AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .instr    (instr),
        .bank_sel (bank_sel),
        .ext_en   (ext_en),
        .idx_ptr  (idx_ptr),
        .kind_q   (kind_q),
        .lit_q    (lit_q),
        .addr_q   (addr_q)
    );

    bmu_prod_unit #(.DW(DW)) u_prod (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .kind     (kind_q),
        .wreg     (wreg),
        .lit      (lit_q),
        .rf_rdata (rf_rdata),
        .prod     (prod)
    );

    // Drive the file read port from the latched address during Q2.
    assign rf_raddr = addr_q;
    assign rf_rd_en = (phase == PH_Q2) && (kind_q == OP_REG);
    assign prod_hi  = prod[2*DW-1:DW];
    assign prod_lo  = prod[DW-1:0];

    // R7
    rd_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en |=> (phase == PH_Q3 && !rf_rd_en));

    // R7
    rd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en |=> $stable(rf_raddr));
endmodule

// File: tb/byte_mul_unit_bench.sv
// Scoreboard bench: the driver pushes expected items, the monitor checks them.
module byte_mul_unit_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic [7:0]  wreg = 8'h00;
    logic [3:0]  bank_sel = 4'h0;
    logic        ext_en = 1'b0;
    logic [11:0] idx_ptr = 12'h000;
    logic [7:0]  rf_rdata;
    logic [11:0] rf_raddr;
    logic        rf_rd_en;
    logic [7:0]  prod_hi;
    logic [7:0]  prod_lo;

    logic        force_on = 1'b0;
    logic [11:0] force_addr = 12'h000;
    logic [7:0]  force_val = 8'h00;
    logic        scramble = 1'b0;
    logic [1:0]  bph = 2'd0;
    logic [15:0] model_prod = 16'h0000;

    int n_chk = 0;
    int n_fail = 0;
    bit ended = 1'b0;

    typedef struct {
        bit          exp_rd;
        logic [11:0] exp_addr;
        logic [15:0] exp_prod;
        logic [15:0] prev_prod;
        string       req;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;

    byte_mul_unit u_byte_mul_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .instr    (instr),
        .wreg     (wreg),
        .bank_sel (bank_sel),
        .ext_en   (ext_en),
        .idx_ptr  (idx_ptr),
        .rf_rdata (rf_rdata),
        .rf_raddr (rf_raddr),
        .rf_rd_en (rf_rd_en),
        .prod_hi  (prod_hi),
        .prod_lo  (prod_lo)
    );

    function automatic logic [7:0] rf_model(input logic [11:0] a);
        return (a[7:0] ^ {a[11:8], ~a[11:8]}) + 8'h13;
    endfunction

    function automatic logic [7:0] file_byte(input logic [11:0] a);
        return (force_on && a == force_addr) ? force_val : rf_model(a);
    endfunction

    assign rf_rdata = (force_on && rf_raddr == force_addr) ? force_val
                    : (rf_model(rf_raddr) ^ (scramble ? 8'hFF : 8'h00));

    // Bench-side phase reference.
    always @(posedge clk) begin
        if (!rst_n) bph <= 2'd0;
        else        bph <= bph + 2'd1;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Drive one instruction cycle from a negedge in Q1; ends at the next Q1 negedge.
    task automatic run(input logic [15:0] ins, input logic [7:0] w, input logic [3:0] bs,
                       input logic e, input logic [11:0] ip, input bit is_lit, input bit is_reg,
                       input logic [11:0] ea, input bit scr, input string req);
        item_t it;
        logic [15:0] p;
        instr = ins; wreg = w; bank_sel = bs; ext_en = e; idx_ptr = ip;
        if (is_lit)      p = 16'(w) * 16'(ins[7:0]);
        else if (is_reg) p = 16'(w) * 16'(file_byte(ea));
        else             p = model_prod;
        it.exp_rd = is_reg; it.exp_addr = ea; it.exp_prod = p;
        it.prev_prod = model_prod; it.req = req;
        sb_q.push_back(it);
        model_prod = p;
        repeat (2) @(posedge clk);
        @(negedge clk);
        scramble = scr;
        repeat (2) @(posedge clk);
        @(negedge clk);
        scramble = 1'b0;
    endtask

    // Monitor: checks the read port in Q2/Q3 and the product after Q4.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && sb_q.size() != 0) begin
                if (bph == 2'd1) begin
                    chk({"R7 strobe ", sb_q[0].req}, {15'd0, rf_rd_en}, {15'd0, sb_q[0].exp_rd});
                    if (sb_q[0].exp_rd)
                        chk({"R7 addr ", sb_q[0].req}, {4'h0, rf_raddr}, {4'h0, sb_q[0].exp_addr});
                    chk({"R8 held ", sb_q[0].req}, {prod_hi, prod_lo}, sb_q[0].prev_prod);
                end else if (bph == 2'd2) begin
                    chk({"R7 no strobe ", sb_q[0].req}, {15'd0, rf_rd_en}, 16'd0);
                end else if (bph == 2'd0) begin
                    chk({"product ", sb_q[0].req}, {prod_hi, prod_lo}, sb_q[0].exp_prod);
                    void'(sb_q.pop_front());
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    // Driver.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset clear", {prod_hi, prod_lo}, 16'h0000);
        rst_n = 1'b1;
        // R1 R3 immediate form
        run(16'h0DC4, 8'hE2, 4'h0, 1'b0, 12'h000, 1, 0, 12'h000, 0, "R1 R3 E2xC4");
        // R2 R3 R4 banked file form with forced B5h
        force_on = 1'b1; force_addr = 12'h340; force_val = 8'hB5;
        run(16'h0340, 8'hC4, 4'h3, 1'b0, 12'h000, 0, 1, 12'h340, 0, "R2 R3 R4 C4xB5");
        force_on = 1'b0;
        // R5 access window, low and high halves
        run(16'h0220, 8'h37, 4'h9, 1'b0, 12'h777, 0, 1, 12'h020, 0, "R5 low window");
        run(16'h0280, 8'h59, 4'h9, 1'b0, 12'h777, 0, 1, 12'hF80, 0, "R5 high window");
        // R6 indexed, boundary 5Fh, wraparound
        run(16'h025F, 8'h81, 4'h2, 1'b1, 12'h100, 0, 1, 12'h15F, 0, "R6 indexed 5F");
        run(16'h0260, 8'h0B, 4'h2, 1'b1, 12'h100, 0, 1, 12'hF60, 0, "R5 R6 offset 60 not indexed");
        run(16'h0220, 8'hA3, 4'h2, 1'b1, 12'hFF0, 0, 1, 12'h010, 0, "R6 wrap");
        // R4 banked ignores ext_en
        run(16'h0310, 8'h6E, 4'hA, 1'b1, 12'h400, 0, 1, 12'hA10, 0, "R4 bank with ext");
        // R9 unmatched words
        run(16'h0E55, 8'h44, 4'h0, 1'b0, 12'h000, 0, 0, 12'h000, 0, "R9 0E55");
        run(16'h0C12, 8'h44, 4'h0, 1'b0, 12'h000, 0, 0, 12'h000, 0, "R9 0C12");
        run(16'h0400, 8'h44, 4'h0, 1'b0, 12'h000, 0, 0, 12'h000, 0, "R9 0400");
        // R3 extremes
        run(16'h0DFF, 8'hFF, 4'h0, 1'b0, 12'h000, 1, 0, 12'h000, 0, "R3 FFxFF");
        run(16'h0D00, 8'h9C, 4'h0, 1'b0, 12'h000, 1, 0, 12'h000, 0, "R3 zero");
        // R11 file data changes after Q2
        run(16'h0330, 8'h03, 4'h5, 1'b0, 12'h000, 0, 1, 12'h530, 1, "R11 late data change");
        // R10 reset in the middle of an instruction
        instr = 16'h0D7F; wreg = 8'h11;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R10 mid-cycle reset clear", {prod_hi, prod_lo}, 16'h0000);
        model_prod = 16'h0000;
        rst_n = 1'b1;
        run(16'h0D05, 8'h03, 4'h0, 1'b0, 12'h000, 1, 0, 12'h000, 0, "R10 restart at Q1");
        wait (sb_q.size() == 0);
        @(negedge clk);
        finish_up();
    end
endmodule